// File: doc/BRIEF.md
# ADC Result Readout Formatter

This block sits between the result registers of a multichannel converter and the byte shift register of its serial port. When a read is requested it takes a snapshot of the current channel result and status. It then presents the bytes of that read one at a time on a valid/ready handshake: the status byte alone, the data bytes alone, or the status byte followed by the data bytes.

Three configuration bits shape the data:
- The width bit chooses a 24-bit or a 16-bit result.
- The clamp bit replaces an out-of-range result with a saturated code.
- The dump bit chains status and data on every read.

A separate continuous-read input always forces the chained ordering. Bytes leave most significant first. In 16-bit mode the top 16 bits of the 24-bit result are sent.

Top module: `adc_readout_fmt`

## Requirements
- R1: After reset, and whenever no byte is offered, `byte_valid` is 0 and `byte_data` is 8'h00.
- R2: With `cfg_dump`=0, `cont_rd`=0 and `rd_sel`=0, a read yields exactly one byte, the status byte. Its bit 7 is `res_rdy`, bits 6:4 are 0, bit 3 is `res_under` OR `res_over`, and bits 2:0 are `res_chan`.
- R3: With `cfg_dump`=0, `cont_rd`=0, `rd_sel`=1 and `cfg_wide`=1, a read yields three bytes: result bits 23:16, then 15:8, then 7:0.
- R4: With `cfg_wide`=0, the data part of a read is two bytes: result bits 23:16, then 15:8.
- R5: With `cfg_clamp`=1, `res_over`=1 and `res_under`=0, every data byte is 8'hFF.
- R6: With `cfg_clamp`=1 and `res_under`=1, every data byte is 8'h00. Under-range wins when both flags are set.
- R7: With `cfg_clamp`=0, the data bytes carry `res_data` unchanged, whatever the range flags are.
- R8: With `cfg_dump`=1, a read with either value of `rd_sel` yields the status byte followed at once by the data bytes.
- R9: With `cont_rd`=1, every read uses the status-then-data ordering, even when `cfg_dump`=0 and `rd_sel`=0.
- R10: Result, status and configuration are sampled at the clock edge that accepts `rd_req`. Changes to these inputs later in the read do not alter its bytes.
- R11: A byte is offered with `byte_valid`=1 and holds stable until the cycle in which `byte_ready`=1. The next byte, if any, appears in the following cycle. After the last byte is accepted, `byte_valid` falls.
- R12: A `rd_req` that arrives while a byte is offered is ignored. It adds no bytes and does not change the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request pulse |
| rd_sel | input | 1 | Register addressed: 0 status, 1 data |
| cont_rd | input | 1 | Continuous-read mode active |
| cfg_dump | input | 1 | Chain status and data on every read |
| cfg_wide | input | 1 | 1: 24-bit data, 0: 16-bit data |
| cfg_clamp | input | 1 | Saturate out-of-range results |
| res_data | input | 24 | Raw channel result |
| res_under | input | 1 | Result below nominal range |
| res_over | input | 1 | Result above nominal range |
| res_chan | input | 3 | Channel number of the result |
| res_rdy | input | 1 | Result-ready flag |
| byte_data | output | 8 | Byte offered to the shift register |
| byte_valid | output | 1 | Byte offered |
| byte_ready | input | 1 | Shift register takes the byte |

## Verification
A wrong byte count shows at the ports on the first read that uses the affected mode. `byte_valid` stays high one cycle too long or falls one cycle early, and the per-clock reference comparison flags it in that cycle. A wrong snapshot or ordering shows as a wrong `byte_data` value no later than the last byte of the read. The bench deliberately changes the result inputs in the middle of reads, so a design that does not sample at the request edge mixes values and fails within a few cycles. A stuck-busy state shows as a read that never starts, and the continuous comparison reports it on the cycle after the request.

// File: rtl/adc_readout_fmt.sv
module adc_readout_fmt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic        rd_sel,
  input  logic        cont_rd,
  input  logic        cfg_dump,
  input  logic        cfg_wide,
  input  logic        cfg_clamp,
  input  logic [23:0] res_data,
  input  logic        res_under,
  input  logic        res_over,
  input  logic [2:0]  res_chan,
  input  logic        res_rdy,
  output logic [7:0]  byte_data,
  output logic        byte_valid,
  input  logic        byte_ready
);

  logic [31:0] sh;
  logic [2:0]  cnt;
  logic [23:0] val;

  wire [7:0]  stat  = {res_rdy, 3'b000, res_under | res_over, res_chan};
  wire        chain = cfg_dump | cont_rd;
  wire [31:0] body  = cfg_wide ? {val, 8'h00} : {val[23:8], 16'h0000};
  wire [2:0]  dlen  = cfg_wide ? 3'd3 : 3'd2;
  wire        start = rd_req && (cnt == 3'd0);
  wire        take  = byte_valid && byte_ready;

  always_comb begin
    if (cfg_clamp && res_under)     val = 24'h000000;
    else if (cfg_clamp && res_over) val = 24'hFFFFFF;
    else                            val = res_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (start) begin
      if (chain) begin
        sh  <= {stat, body[31:8]};
        cnt <= dlen + 3'd1;
      end else if (rd_sel) begin
        sh  <= body;
        cnt <= dlen;
      end else begin
        sh  <= {stat, 24'h000000};
        cnt <= 3'd1;
      end
    end else if (take) begin
      sh  <= {sh[23:0], 8'h00};
      cnt <= cnt - 3'd1;
    end
  end

  assign byte_valid = (cnt != 3'd0);
  assign byte_data  = sh[31:24];

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_data));

  // R11
  last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && cnt == 3'd1 |=> !byte_valid && byte_data == 8'h00);

  // R12
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && byte_valid && !byte_ready |=> byte_valid);

  // R8 R9
  chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !byte_valid && (cfg_dump || cont_rd)
    |=> byte_data == {$past(res_rdy), 3'b000, $past(res_under | res_over), $past(res_chan)});

  // R5
  clamp_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !byte_valid && !cfg_dump && !cont_rd && rd_sel && cfg_clamp && res_over && !res_under
    |=> byte_data == 8'hFF);

  // R6
  clamp_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !byte_valid && !cfg_dump && !cont_rd && rd_sel && cfg_clamp && res_under
    |=> byte_data == 8'h00);

endmodule

// File: tb/sim_adc_readout_fmt.sv
`timescale 1ns/1ps
module sim_adc_readout_fmt;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req = 1'b0, rd_sel = 1'b0, cont_rd = 1'b0;
  logic cfg_dump = 1'b0, cfg_wide = 1'b1, cfg_clamp = 1'b0;
  logic [23:0] res_data = '0;
  logic res_under = 1'b0, res_over = 1'b0, res_rdy = 1'b0;
  logic [2:0] res_chan = '0;
  logic byte_ready = 1'b1;
  logic [7:0] byte_data;
  logic byte_valid;

  int checks = 0, fails = 0, cycles = 0;
  bit rnd_ready = 0, armed = 0;
  string cur_req = "R1";
  byte unsigned q[$];

  always #4 clk = ~clk;

  adc_readout_fmt u0 (.clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_sel(rd_sel),
    .cont_rd(cont_rd), .cfg_dump(cfg_dump), .cfg_wide(cfg_wide), .cfg_clamp(cfg_clamp),
    .res_data(res_data), .res_under(res_under), .res_over(res_over), .res_chan(res_chan),
    .res_rdy(res_rdy), .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready));

  always @(posedge clk) begin
    if (!rst_n) q.delete();
    else begin
      bit had;
      had = (q.size() != 0);
      if (had && byte_ready) void'(q.pop_front());
      if (!had && rd_req) begin
        bit chain;
        logic [23:0] d;
        chain = cfg_dump || cont_rd;
        d = (cfg_clamp && res_under) ? 24'h000000 :
            (cfg_clamp && res_over)  ? 24'hFFFFFF : res_data;
        if (chain || !rd_sel) q.push_back({res_rdy, 3'b000, res_under | res_over, res_chan});
        if (chain || rd_sel) begin
          q.push_back(d[23:16]);
          q.push_back(d[15:8]);
          if (cfg_wide) q.push_back(d[7:0]);
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rnd_ready) byte_ready <= ($urandom_range(0, 2) != 0);
    else byte_ready <= 1'b1;
    if (armed) begin
      bit ev;
      logic [7:0] ed;
      ev = (q.size() != 0);
      ed = ev ? q[0] : 8'h00;
      checks++;
      if (byte_valid !== ev || byte_data !== ed) begin
        fails++;
        $display("FAIL %s: valid=%0b data=%02h expected valid=%0b data=%02h",
                 cur_req, byte_valid, byte_data, ev, ed);
      end
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic do_read(input string tag, input bit sel, input bit dump, input bit cont,
                         input bit wide, input bit clamp, input logic [23:0] d,
                         input bit un, input bit ov, input logic [2:0] ch, input bit rdy,
                         input bit scramble = 0, input bit poke = 0);
    @(negedge clk);
    cur_req = tag;
    rd_sel = sel; cfg_dump = dump; cont_rd = cont; cfg_wide = wide; cfg_clamp = clamp;
    res_data = d; res_under = un; res_over = ov; res_chan = ch; res_rdy = rdy;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    if (scramble) begin
      res_data = ~d; res_under = ~un; res_over = ~ov; res_chan = ~ch; res_rdy = ~rdy;
      cfg_wide = ~wide; cfg_clamp = ~clamp; rd_sel = ~sel;
    end
    while (q.size() != 0) begin
      if (poke) rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    armed = 1;
    cur_req = "R1";
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_read("R2", 0, 0, 0, 1, 0, 24'h123456, 0, 1, 3'd5, 1);
    do_read("R2", 0, 0, 0, 1, 0, 24'h123456, 1, 0, 3'd2, 0);
    do_read("R2", 0, 0, 0, 0, 0, 24'h000000, 0, 0, 3'd7, 1);
    do_read("R3", 1, 0, 0, 1, 0, 24'hA5C3E1, 0, 0, 3'd1, 1);
    do_read("R4", 1, 0, 0, 0, 0, 24'h123456, 0, 0, 3'd1, 1);
    do_read("R5", 1, 0, 0, 1, 1, 24'h7ABCDE, 0, 1, 3'd3, 1);
    do_read("R5", 1, 0, 0, 0, 1, 24'h7ABCDE, 0, 1, 3'd3, 1);
    do_read("R6", 1, 0, 0, 1, 1, 24'h80F00F, 1, 0, 3'd4, 1);
    do_read("R6", 1, 0, 0, 1, 1, 24'h80F00F, 1, 1, 3'd4, 1);
    do_read("R7", 1, 0, 0, 1, 0, 24'hFEDCBA, 0, 1, 3'd6, 1);
    do_read("R7", 1, 0, 0, 1, 0, 24'h010203, 1, 0, 3'd6, 0);
    do_read("R8", 0, 1, 0, 1, 0, 24'h9ABCDE, 0, 0, 3'd2, 1);
    do_read("R8", 1, 1, 0, 0, 1, 24'h9ABCDE, 0, 1, 3'd2, 1);
    do_read("R9", 0, 0, 1, 1, 0, 24'h314159, 0, 0, 3'd0, 1);
    do_read("R9", 1, 0, 1, 0, 0, 24'h271828, 1, 0, 3'd7, 0);
    do_read("R10", 1, 0, 0, 1, 0, 24'h55AA33, 0, 0, 3'd3, 1, 1);
    do_read("R10", 0, 1, 0, 1, 1, 24'h0F0F0F, 0, 1, 3'd5, 0, 1);
    do_read("R12", 1, 1, 0, 1, 0, 24'hC0FFEE, 0, 0, 3'd1, 1, 0, 1);
    rnd_ready = 1;
    do_read("R11", 1, 0, 0, 1, 0, 24'hBEEF42, 0, 0, 3'd2, 1);
    do_read("R12", 0, 0, 1, 1, 0, 24'h13579B, 0, 0, 3'd4, 1, 0, 1);
    for (int i = 0; i < 60; i++)
      do_read("R11", 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              24'($urandom), 1'($urandom), 1'($urandom), 3'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom));
    rnd_ready = 0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule